// File: doc/BRIEF.md
# Chip-Select-Timed Converter Power Mode Controller

This block decides the power state of a sampling converter (fully on, partly off, fully off) from one fact per conversion frame: how many serial-clock falling edges had been seen when chip select went back high. There is no register access. The host steers the power state purely through frame timing. A short aborted frame steps the part down one level. A frame held long enough steps it straight back to fully on.

Chip select (active low) and the serial clock are asynchronous inputs. Both are brought into a free-running system clock domain through a synchroniser chain, and their edges are detected there. The same clock drives a power-up timer. That timer covers the extra settling time needed when waking from the deepest state. The outputs are the encoded power state, an enable for the analog core, an enable for the reference and its buffer, a busy flag for the power-up timer, and a data-valid flag. Data-valid tells downstream logic whether the result of the frame in progress can be trusted.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state is normal (code 0), analog_en and ref_en are 1, and data_valid and busy are 0.
- R2: If chip select rises after fewer than GLITCH_EDGES (default 2) serial-clock falling edges in the frame, the power state is left unchanged.
- R3: From normal, a chip-select rise after 2 to 9 falling edges moves the state to partial power-down (code 1).
- R4: From partial power-down, a chip-select rise after 2 to 9 falling edges moves the state to full power-down (code 2). From full power-down, such a frame leaves it in full power-down.
- R5: Once the 10th falling edge (PWRUP_EDGE) of a frame is seen, the state becomes normal whatever it was before. A later rise of chip select, before or after the 16th edge, does not power the part down. The state code is never 3.
- R6: While chip select is high, the enables follow the state: in normal both are 1, in partial only ref_en is 1, and in full both are 0. While chip select is low, both enables are 1.
- R7: data_valid is 1 only while chip select is low, and only in a frame that began in the normal state with busy low. A wake-up (dummy) frame from either power-down state therefore gives invalid data, and the frame after it can be valid.
- R8: Reaching normal from full power-down raises busy for PWRUP_CYCLES system clocks. A frame that begins while busy is high has data_valid 0.
- R9: Chip select passes through SYNC_STAGES (default 2) system-clock flops. With the default, the enables respond to a chip-select fall after exactly 2 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles high, asynchronous |
| pwr_state | output | 2 | Power state: 0 normal, 1 partial, 2 full |
| analog_en | output | 1 | Analog core enable |
| ref_en | output | 1 | Reference and buffer enable |
| data_valid | output | 1 | Current frame result is trustworthy |
| busy | output | 1 | Power-up timer running |

## Verification
A miscounted edge window or a wrong transition shows on pwr_state and the enable pins within a few system clocks of the chip-select rise. The bench therefore sweeps every edge count from 0 to 17 from each of the three starting states and compares against a model it computes itself. A lost or stuck power-up timer shows as busy or data_valid being wrong in the first frame after a wake-up from full power-down. A wrong synchroniser depth shows as the enables moving one cycle early or late after chip select falls.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [1:0] {
      PWR_NORMAL  = 2'd0,
      PWR_PARTIAL = 2'd1,
      PWR_FULL    = 2'd2
   } pwr_state_t;

   function automatic pwr_state_t step_down(input pwr_state_t cur);
      case (cur)
         PWR_NORMAL:  step_down = PWR_PARTIAL;
         PWR_PARTIAL: step_down = PWR_FULL;
         default:     step_down = PWR_FULL;
      endcase
   endfunction

endpackage

// File: rtl/cs_sclk_sync.sv
module cs_sclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_in,
   input  logic sclk_in,
   output logic in_frame,
   output logic frame_start,
   output logic frame_end,
   output logic sclk_fall
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] cs_q;
   logic [STAGES-1:0] sk_q;
   logic              cs_d;
   logic              sk_d;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_q[0] <= 1'b1;
               sk_q[0] <= 1'b1;
            end else begin
               cs_q[0] <= cs_n_in;
               sk_q[0] <= sclk_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_q[s] <= 1'b1;
               sk_q[s] <= 1'b1;
            end else begin
               cs_q[s] <= cs_q[s-1];
               sk_q[s] <= sk_q[s-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d <= 1'b1;
         sk_d <= 1'b1;
      end else begin
         cs_d <= cs_q[LAST];
         sk_d <= sk_q[LAST];
      end
   end

   assign in_frame    = ~cs_q[LAST];
   assign frame_start = cs_d & ~cs_q[LAST];
   assign frame_end   = ~cs_d & cs_q[LAST];
   assign sclk_fall   = sk_d & ~sk_q[LAST] & ~cs_q[LAST];

endmodule

// File: rtl/frame_edge_counter.sv
module frame_edge_counter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bump,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (bump && count != CNT_MAX) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/powerup_timer.sv
module powerup_timer #(
   parameter int CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   output logic busy
);
   if (CYCLES == 0) begin : g_none
      assign busy = 1'b0;
   end else begin : g_count
      localparam int TW = $clog2(CYCLES + 1);
      localparam logic [TW-1:0] LOAD = TW'(CYCLES);
      logic [TW-1:0] remain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            remain <= '0;
         end else if (cancel) begin
            remain <= '0;
         end else if (start) begin
            remain <= LOAD;
         end else if (remain != '0) begin
            remain <= remain - 1'b1;
         end
      end

      assign busy = (remain != '0);
   end

endmodule

// File: rtl/power_mode_fsm.sv
module power_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter int CNT_W        = 6,
   parameter int GLITCH_EDGES = 2,
   parameter int PWRUP_EDGE   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             frame_end,
   input  logic             sclk_fall,
   input  logic [CNT_W-1:0] edges,
   input  logic             busy,
   output pwr_state_t       state,
   output logic             timer_start,
   output logic             timer_cancel,
   output logic             frame_ok
);
   localparam logic [CNT_W-1:0] GLITCH_CNT = CNT_W'(GLITCH_EDGES);
   localparam logic [CNT_W-1:0] WAKE_CNT   = CNT_W'(PWRUP_EDGE);
   localparam logic [CNT_W-1:0] WAKE_PRE   = CNT_W'(PWRUP_EDGE - 1);

   logic       abort_window;
   logic       wake_hit;
   pwr_state_t state_nx;

   assign abort_window = frame_end && (edges >= GLITCH_CNT) && (edges < WAKE_CNT);
   assign wake_hit     = sclk_fall && (edges == WAKE_PRE);

   always_comb begin
      state_nx     = state;
      timer_start  = 1'b0;
      timer_cancel = 1'b0;
      if (abort_window) begin
         state_nx     = step_down(state);
         timer_cancel = 1'b1;
      end else if (wake_hit && state != PWR_NORMAL) begin
         state_nx    = PWR_NORMAL;
         timer_start = (state == PWR_FULL);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PWR_NORMAL;
         frame_ok <= 1'b0;
      end else begin
         state <= state_nx;
         if (frame_start) begin
            frame_ok <= (state == PWR_NORMAL) && !busy;
         end else if (frame_end) begin
            frame_ok <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int CNT_W        = 6,
   parameter int GLITCH_EDGES = 2,
   parameter int PWRUP_EDGE   = 10,
   parameter int FRAME_EDGES  = 16,
   parameter int PWRUP_CYCLES = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   output logic [1:0] pwr_state,
   output logic       analog_en,
   output logic       ref_en,
   output logic       data_valid,
   output logic       busy
);
   localparam int CNT_LIMIT = (1 << CNT_W) - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (GLITCH_EDGES < 1 || GLITCH_EDGES >= PWRUP_EDGE) begin : g_bad_glitch
      $error("GLITCH_EDGES must lie between 1 and PWRUP_EDGE-1");
   end
   if (PWRUP_EDGE > FRAME_EDGES) begin : g_bad_wake
      $error("PWRUP_EDGE must not exceed FRAME_EDGES");
   end
   if (FRAME_EDGES > CNT_LIMIT) begin : g_bad_width
      $error("CNT_W too narrow for FRAME_EDGES");
   end
   if (PWRUP_CYCLES < 0) begin : g_bad_cycles
      $error("PWRUP_CYCLES must not be negative");
   end

   logic             in_frame;
   logic             frame_start;
   logic             frame_end;
   logic             sclk_fall;
   logic [CNT_W-1:0] edges;
   logic             timer_start;
   logic             timer_cancel;
   logic             frame_ok;
   pwr_state_t       state;

   cs_sclk_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_in     (cs_n),
      .sclk_in     (sclk),
      .in_frame    (in_frame),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .sclk_fall   (sclk_fall)
   );

   frame_edge_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (frame_start),
      .bump  (sclk_fall),
      .count (edges)
   );

   power_mode_fsm #(
      .CNT_W        (CNT_W),
      .GLITCH_EDGES (GLITCH_EDGES),
      .PWRUP_EDGE   (PWRUP_EDGE)
   ) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_start  (frame_start),
      .frame_end    (frame_end),
      .sclk_fall    (sclk_fall),
      .edges        (edges),
      .busy         (busy),
      .state        (state),
      .timer_start  (timer_start),
      .timer_cancel (timer_cancel),
      .frame_ok     (frame_ok)
   );

   powerup_timer #(.CYCLES(PWRUP_CYCLES)) tmr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (timer_start),
      .cancel (timer_cancel),
      .busy   (busy)
   );

   assign pwr_state  = state;
   assign analog_en  = (state == PWR_NORMAL) || in_frame;
   assign ref_en     = (state != PWR_FULL) || in_frame;
   assign data_valid = frame_ok && in_frame && !busy;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] pwr_state,
   input logic       busy,
   input logic       data_valid,
   input logic       in_frame,
   input logic       analog_en,
   input logic       ref_en
);
   // R5: the unused code never appears
   assert_no_code3_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state != 2'd3);

   // R4: full power-down is entered only from partial (or held)
   assert_full_from_partial_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2) |-> ($past(pwr_state) == 2'd1 || $past(pwr_state) == 2'd2));

   // R3: partial power-down is entered only from normal (or held)
   assert_partial_from_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd1) |-> ($past(pwr_state) == 2'd0 || $past(pwr_state) == 2'd1));

   // R8: the timer only starts on the way into normal
   assert_busy_start_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (pwr_state == 2'd0 && $past(pwr_state) == 2'd2));

   // R7: valid data only inside a frame, in normal, not busy
   assert_valid_context_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (in_frame && pwr_state == 2'd0 && !busy));

   // R5: inside a frame the state may only move towards normal
   assert_frame_wake_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && $past(in_frame) && pwr_state != $past(pwr_state)) |-> (pwr_state == 2'd0));

   // R6: a frame in progress keeps both supplies on
   assert_frame_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame |-> (analog_en && ref_en));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_state  (pwr_state),
   .busy       (busy),
   .data_valid (data_valid),
   .in_frame   (in_frame),
   .analog_en  (analog_en),
   .ref_en     (ref_en)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PWRUP_CY   = 300;
   localparam int HALF_SCLK  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b1;
   logic [1:0] pwr_state;
   logic       analog_en;
   logic       ref_en;
   logic       data_valid;
   logic       busy;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctrl #(.PWRUP_CYCLES(PWRUP_CY)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .sclk       (sclk),
      .pwr_state  (pwr_state),
      .analog_en  (analog_en),
      .ref_en     (ref_en),
      .data_valid (data_valid),
      .busy       (busy)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_next(input int st, input int n);
      if (n >= 10) return 0;
      if (n >= 2) return (st == 0) ? 1 : 2;
      return st;
   endfunction

   task automatic wait_clk(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic do_reset();
      cs_n = 1'b1;
      sclk = 1'b1;
      rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(3);
   endtask

   // one frame with n falling edges; exp_dv is the expected data_valid early in it
   task automatic frame(input int n, input int exp_dv, input string req);
      cs_n = 1'b0;
      wait_clk(10);
      check(req, "data_valid in frame", int'(data_valid), exp_dv);
      check("R6", "enables in frame", int'({analog_en, ref_en}), 3);
      for (int i = 0; i < n; i++) begin
         sclk = 1'b0;
         wait_clk(HALF_SCLK);
         sclk = 1'b1;
         wait_clk(HALF_SCLK);
      end
      cs_n = 1'b1;
      wait_clk(12);
   endtask

   task automatic check_idle(input int st, input string req);
      check(req, "pwr_state", int'(pwr_state), st);
      check("R6", "analog_en idle", int'(analog_en), (st == 0) ? 1 : 0);
      check("R6", "ref_en idle", int'(ref_en), (st == 2) ? 0 : 1);
      check("R7", "data_valid idle", int'(data_valid), 0);
   endtask

   task automatic reach(input int st);
      do_reset();
      for (int k = 0; k < st; k++) frame(5, (k == 0) ? 1 : 0, "R7");
   endtask

   initial begin
      // R1: reset state
      do_reset();
      check("R1", "pwr_state", int'(pwr_state), 0);
      check("R1", "enables", int'({analog_en, ref_en}), 3);
      check("R1", "data_valid", int'(data_valid), 0);
      check("R1", "busy", int'(busy), 0);

      // sweep: every start state against edge counts 0..17 (R2 R3 R4 R5)
      for (int st = 0; st < 3; st++) begin
         for (int n = 0; n < 18; n++) begin
            int nx;
            string rq;
            reach(st);
            nx = exp_next(st, n);
            if (n < 2) rq = "R2";
            else if (n >= 10) rq = "R5";
            else if (st == 0) rq = "R3";
            else rq = "R4";
            frame(n, (st == 0) ? 1 : 0, "R7");
            check_idle(nx, rq);
            check("R8", "busy after frame", int'(busy), (st == 2 && n >= 10) ? 1 : 0);
         end
      end

      // R8: wake from full, busy blocks valid data, then clears
      reach(2);
      frame(12, 0, "R7");
      check("R8", "busy after wake", int'(busy), 1);
      frame(16, 0, "R8");
      wait_clk(PWRUP_CY + 20);
      check("R8", "busy cleared", int'(busy), 0);
      frame(16, 1, "R8");
      check_idle(0, "R5");

      // R7: the frame after a partial wake-up is valid
      reach(1);
      frame(10, 0, "R7");
      check("R7", "no busy after partial wake", int'(busy), 0);
      frame(16, 1, "R7");

      // R9: synchroniser latency of the enables
      reach(1);
      cs_n = 1'b0;
      wait_clk(1);
      check("R9", "analog_en after 1 clk", int'(analog_en), 0);
      wait_clk(1);
      check("R9", "analog_en after 2 clk", int'(analog_en), 1);
      cs_n = 1'b1;
      wait_clk(8);
      check_idle(1, "R2");

      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule